// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 interrupt input lines and drives a single active-low request to a processor. Software configures each input through its own control word. The word chooses how the input is sensed, as a low level, a high level, a falling edge or a rising edge. It also gives the input a 3-bit urgency value. Edge events are held in a per-input latch. Level inputs are re-sampled every cycle. Software can also force an input pending or clear it.

The controller selects one winner among the inputs that are pending and enabled. While nothing is in service, the winner pulls the request line low. The handler reads the priority-encoding register, which returns the winner's number and places that input in service. The request line is released while a source is in service. A write of any value to the end-of-service register ends the service, and the next winner can then raise the line. Enables are changed only through two write-one command registers, one that sets enable bits and one that clears them. All access goes through a plain 32-bit register bus with separate read and write strobes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every input is disabled, nothing is pending, no input is in service, every control word reads 0, `irq_n` is high and `bus_rdata` is 0.
- R2: The control word of input n sits at byte address 4·n. Bits 7:6 hold the sense mode (0 low level, 1 high level, 2 falling edge, 3 rising edge) and bits 2:0 hold the urgency. A read returns only those bits and returns zeros elsewhere.
- R3: A level-mode input is pending for exactly as long as its line sits at the selected level, one clock later. The raw register (0x100) shows it, and a priority-encoding read does not clear it.
- R4: An edge-mode input latches the selected edge one clock after the edge. It stays pending while the line holds still, until a priority-encoding read takes it into service or a source-clear command clears it.
- R5: A write to 0x120 enables every input whose data bit is 1, and a write to 0x124 disables every input whose data bit is 1. Zero bits leave the enables unchanged. 0x114 reads the enable bits with 1 meaning enabled. 0x100 shows raw pending state whatever the enables are, and 0x108 shows raw AND enable.
- R6: A write to 0x128 makes every flagged input pending, and a write to 0x12C withdraws the latched pending state of every flagged input.
- R7: Among enabled pending inputs, the smallest urgency value wins. When two inputs share that value, the lower input number wins.
- R8: `irq_n` is low exactly when a winner exists and nothing is in service. A read of 0x10C returns the winner's number in bits 4:0 and sets bit 31 when a winner exists. When nothing was in service, that read places the winner in service, so `irq_n` is high from the next cycle. 0x104 then shows the in-service input one-hot, and 0x110 returns its number with no side effect. With no winner, the 0x10C read returns 0 and changes nothing.
- R9: A write of any value to 0x130 ends the service. If a winner exists, `irq_n` goes low again in the next cycle.
- R10: Bit 0 of 0x118 reads 1 while the request line is asserted.
- R11: Read data is registered. `bus_rdata` takes the addressed value at the clock edge that samples `bus_rd` and then holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt input lines, synchronous to `clk` |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Every effect in this block lands one clock edge after its cause. An input change shows up in the raw state and on `irq_n` after one edge. The same holds for a command, enable or control write, whose effect is seen at the next read or on `irq_n`. A priority-encoding read or end-of-service write moves `irq_n` after the edge that samples the strobe, and `bus_rdata` carries a read's value after that same edge. The bench drives each strobe or line change at a falling edge and samples at the following falling edge, so each result is checked half a cycle after the edge that produces it. Arbitration cases are read back one service at a time, with an end-of-service write between them, so the full winner order is visible at the port.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_RISE = 2'd3
  } sense_e;

  localparam logic [11:0] OFS_RAW  = 12'h100;
  localparam logic [11:0] OFS_ACT  = 12'h104;
  localparam logic [11:0] OFS_STAT = 12'h108;
  localparam logic [11:0] OFS_PE   = 12'h10C;
  localparam logic [11:0] OFS_NUM  = 12'h110;
  localparam logic [11:0] OFS_EN   = 12'h114;
  localparam logic [11:0] OFS_OUT  = 12'h118;
  localparam logic [11:0] OFS_ENS  = 12'h120;
  localparam logic [11:0] OFS_ENC  = 12'h124;
  localparam logic [11:0] OFS_SSET = 12'h128;
  localparam logic [11:0] OFS_SCLR = 12'h12C;
  localparam logic [11:0] OFS_EOS  = 12'h130;

  // Level sense: true while the sampled line sits at the selected level.
  function automatic logic level_hit(input sense_e mode, input logic line_q);
    case (mode)
      SENSE_LOW:  level_hit = !line_q;
      SENSE_HIGH: level_hit = line_q;
      default:    level_hit = 1'b0;
    endcase
  endfunction

  // Edge sense: true when the line moves in the selected direction.
  function automatic logic edge_hit(input sense_e mode, input logic prev, input logic now);
    case (mode)
      SENSE_FALL: edge_hit = prev && !now;
      SENSE_RISE: edge_hit = !prev && now;
      default:    edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irqc_source.sv
module irqc_source
  import irqc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_i,
  input  sense_e mode,
  input  logic   sw_set,
  input  logic   sw_clr,
  input  logic   svc_clr,
  output logic   edge_evt,
  output logic   raw
);

  logic line_q;
  logic latched;

  assign edge_evt = edge_hit(mode, line_q, line_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      latched <= 1'b0;
    end else begin
      line_q  <= line_i;
      latched <= (latched && !(sw_clr || svc_clr)) || edge_evt || sw_set;
    end
  end

  assign raw = latched || level_hit(mode, line_q);

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N  = 32,
  parameter int PW = 3,
  parameter int IW = 5
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio_flat,
  output logic            valid,
  output logic [IW-1:0]   id
);

  logic [PW-1:0] best;

  // Ascending scan: only a strictly smaller urgency displaces the holder,
  // so ties stay with the lowest index.
  always_comb begin
    valid = 1'b0;
    id    = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!valid || (prio_flat[i*PW +: PW] < best))) begin
        valid = 1'b1;
        id    = IW'(i);
        best  = prio_flat[i*PW +: PW];
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);

  localparam int IDX_W      = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CTRL_SPAN  = NSRC * 4;
  localparam int MODE_LSB   = 6;

  // Named internal events, also observed by the bound checker.
  logic [NSRC-1:0]   raw;
  logic [NSRC-1:0]   stat;
  logic [NSRC-1:0]   en_q;
  logic [NSRC-1:0]   edge_evt;
  logic [NSRC-1:0]   svc_clr;
  logic              win_valid;
  logic [IDX_W-1:0]  win_id;
  logic              in_svc;
  logic [IDX_W-1:0]  svc_id;
  logic              take;
  logic              eos_wr;

  sense_e            mode_q [NSRC];
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [NSRC*PRIO_W-1:0] prio_flat;

  // Address decode
  logic             ctrl_hit;
  logic [IDX_W-1:0] ctrl_idx;
  logic             ens_wr, enc_wr, sset_wr, sclr_wr, pe_rd;

  assign ctrl_hit = (bus_addr < ADDR_W'(CTRL_SPAN)) && (bus_addr[1:0] == 2'b00);
  assign ctrl_idx = bus_addr[IDX_W+1:2];
  assign ens_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_ENS));
  assign enc_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_ENC));
  assign sset_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_SSET));
  assign sclr_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_SCLR));
  assign eos_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_EOS));
  assign pe_rd    = bus_rd && (bus_addr == ADDR_W'(OFS_PE));

  assign take    = pe_rd && win_valid && !in_svc;
  assign svc_clr = take ? (NSRC'(1) << win_id) : '0;

  // Per-source control words and sensing
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[g] <= SENSE_LOW;
        prio_q[g] <= '0;
      end else if (bus_wr && ctrl_hit && (ctrl_idx == IDX_W'(g))) begin
        mode_q[g] <= sense_e'(bus_wdata[MODE_LSB+1:MODE_LSB]);
        prio_q[g] <= bus_wdata[PRIO_W-1:0];
      end
    end

    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];

    irqc_source u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (src_i[g]),
      .mode     (mode_q[g]),
      .sw_set   (sset_wr && bus_wdata[g]),
      .sw_clr   (sclr_wr && bus_wdata[g]),
      .svc_clr  (svc_clr[g]),
      .edge_evt (edge_evt[g]),
      .raw      (raw[g])
    );
  end

  // Enable bits, changed only through the two command registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (ens_wr) begin
      en_q <= en_q | bus_wdata[NSRC-1:0];
    end else if (enc_wr) begin
      en_q <= en_q & ~bus_wdata[NSRC-1:0];
    end
  end

  assign stat = raw & en_q;

  irqc_arbiter #(
    .N  (NSRC),
    .PW (PRIO_W),
    .IW (IDX_W)
  ) u_arb (
    .req       (stat),
    .prio_flat (prio_flat),
    .valid     (win_valid),
    .id        (win_id)
  );

  // Service slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc <= 1'b0;
      svc_id <= '0;
    end else if (eos_wr) begin
      in_svc <= 1'b0;
    end else if (take) begin
      in_svc <= 1'b1;
      svc_id <= win_id;
    end
  end

  assign irq_n = !(win_valid && !in_svc);

  // Read path
  function automatic logic [DATA_W-1:0] widen(input logic [NSRC-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NSRC-1:0] = v;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] number(input logic [IDX_W-1:0] n);
    logic [DATA_W-1:0] w;
    w = '0;
    w[IDX_W-1:0] = n;
    return w;
  endfunction

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (ctrl_hit) begin
      rd_val[MODE_LSB+1:MODE_LSB] = mode_q[ctrl_idx];
      rd_val[PRIO_W-1:0]          = prio_q[ctrl_idx];
    end else begin
      case (bus_addr)
        ADDR_W'(OFS_RAW):  rd_val = widen(raw);
        ADDR_W'(OFS_ACT):  rd_val = in_svc ? widen(NSRC'(1) << svc_id) : '0;
        ADDR_W'(OFS_STAT): rd_val = widen(stat);
        ADDR_W'(OFS_PE): begin
          if (win_valid) begin
            rd_val = number(win_id);
            rd_val[DATA_W-1] = 1'b1;
          end
        end
        ADDR_W'(OFS_NUM):  rd_val = number(svc_id);
        ADDR_W'(OFS_EN):   rd_val = widen(en_q);
        ADDR_W'(OFS_OUT):  rd_val = DATA_W'(!irq_n);
        default:           rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_n,
  input logic [NSRC-1:0]   raw,
  input logic [NSRC-1:0]   stat,
  input logic [NSRC-1:0]   en_q,
  input logic              win_valid,
  input logic [IDX_W-1:0]  win_id,
  input logic              in_svc,
  input logic              take,
  input logic              eos_wr
);

  AST_TAKE_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> irq_n); // R8

  AST_LINE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (stat != '0)); // R8

  AST_EOS_ENDS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    eos_wr |=> !in_svc); // R9

  AST_DISABLE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ENC) && (&bus_wdata[NSRC-1:0])) |=> (en_q == '0)); // R5

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ENS))
      |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R5

  AST_SET_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_SSET))
      |=> ((raw & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R6

  AST_WINNER_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> stat[win_id]); // R7

endmodule

bind irq_prio_ctrl irqc_checker #(
  .NSRC   (NSRC),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .irq_n     (irq_n),
  .raw       (raw),
  .stat      (stat),
  .en_q      (en_q),
  .win_valid (win_valid),
  .win_id    (win_id),
  .in_svc    (in_svc),
  .take      (take),
  .eos_wr    (eos_wr)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = 32'hFFFF_FFFF;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // {is_read, address, write data, expected read}
  localparam int NVEC = 20;
  localparam logic [76:0] VEC [NVEC] = '{
    {1'b1, 12'h100, 32'h0,         32'h0},         // R1 nothing raw
    {1'b1, 12'h114, 32'h0,         32'h0},         // R1 all disabled
    {1'b1, 12'h014, 32'h0,         32'h0},         // R1 control word 0
    {1'b0, 12'h014, 32'hFFFF_FFC5, 32'h0},         // R2 rising, urgency 5
    {1'b1, 12'h014, 32'h0,         32'h0000_00C5}, // R2 only mode/urgency bits
    {1'b0, 12'h028, 32'h0000_0041, 32'h0},         // R3 input 10 high level
    {1'b1, 12'h100, 32'h0,         32'h0000_0400}, // R3 raw follows level
    {1'b1, 12'h108, 32'h0,         32'h0},         // R5 disabled hides it
    {1'b0, 12'h120, 32'h0000_0400, 32'h0},         // R5 enable 10
    {1'b1, 12'h114, 32'h0,         32'h0000_0400}, // R5
    {1'b1, 12'h108, 32'h0,         32'h0000_0400}, // R5
    {1'b1, 12'h110, 32'h0,         32'h0},         // R8 no service yet
    {1'b0, 12'h128, 32'h0000_0001, 32'h0},         // R6 force input 0
    {1'b1, 12'h100, 32'h0,         32'h0000_0401}, // R6
    {1'b1, 12'h108, 32'h0,         32'h0000_0400}, // R5 input 0 disabled
    {1'b0, 12'h12C, 32'h0000_0001, 32'h0},         // R6 clear input 0
    {1'b1, 12'h100, 32'h0,         32'h0000_0400}, // R6
    {1'b0, 12'h124, 32'hFFFF_FFFF, 32'h0},         // R5 disable all
    {1'b1, 12'h114, 32'h0,         32'h0},         // R5
    {1'b1, 12'h118, 32'h0,         32'h0}          // R10 no request
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state seen at the ports
    check("R1 irq_n", {31'b0, irq_n}, 32'h1);
    check("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][76]) begin
        rd(VEC[i][75:64], d);
        check($sformatf("vector %0d", i), d, VEC[i][31:0]);
      end else begin
        wr(VEC[i][75:64], VEC[i][63:32]);
      end
    end

    // R4 rising edge on input 5 and the service handshake (R8)
    wr(12'h120, 32'h0000_0020);
    @(negedge clk); src_i[5] = 1'b0;
    @(negedge clk); src_i[5] = 1'b1;
    @(negedge clk);
    check("R4 rise latched irq_n", {31'b0, irq_n}, 32'h0);
    rd_chk("R10 request shown", 12'h118, 32'h1);
    rd_chk("R8 pe read", 12'h10C, 32'h8000_0005);
    check("R8 line released", {31'b0, irq_n}, 32'h1);
    rd_chk("R8 active one-hot", 12'h104, 32'h0000_0020);
    rd_chk("R8 number", 12'h110, 32'h5);
    rd_chk("R4 latch taken", 12'h100, 32'h0000_0400);
    wr(12'h130, 32'h0);
    check("R9 nothing left", {31'b0, irq_n}, 32'h1);
    rd_chk("R9 active cleared", 12'h104, 32'h0);

    // R7 ties go to the lower number, then urgency beats number
    wr(12'h00C, 32'h0000_00C2);
    wr(12'h01C, 32'h0000_00C2);
    wr(12'h050, 32'h0000_00C6);
    wr(12'h120, 32'h0010_0088);
    wr(12'h128, 32'h0010_0088);
    check("R8 request", {31'b0, irq_n}, 32'h0);
    rd_chk("R7 tie low number", 12'h10C, 32'h8000_0003);
    check("R8 released", {31'b0, irq_n}, 32'h1);
    rd_chk("R8 busy read no change", 12'h110, 32'h3);
    wr(12'h130, 32'h0);
    check("R9 re-armed", {31'b0, irq_n}, 32'h0);
    rd_chk("R7 second", 12'h10C, 32'h8000_0007);
    wr(12'h130, 32'h0);
    rd_chk("R7 third", 12'h10C, 32'h8000_0014);
    wr(12'h130, 32'h0);
    check("R9 idle", {31'b0, irq_n}, 32'h1);
    wr(12'h064, 32'h0000_00C0);
    wr(12'h008, 32'h0000_00C7);
    wr(12'h120, 32'h0200_0004);
    wr(12'h128, 32'h0200_0004);
    rd_chk("R7 urgency first", 12'h10C, 32'h8000_0019);
    wr(12'h130, 32'h0);
    rd_chk("R7 urgency second", 12'h10C, 32'h8000_0002);
    wr(12'h130, 32'h0);

    // R4 falling edge on input 9, withdrawn by the clear command
    wr(12'h024, 32'h0000_0084);
    wr(12'h120, 32'h0000_0200);
    @(negedge clk); src_i[9] = 1'b0;
    @(negedge clk);
    check("R4 fall latched irq_n", {31'b0, irq_n}, 32'h0);
    rd_chk("R4 raw", 12'h100, 32'h0000_0600);
    wr(12'h12C, 32'h0000_0200);
    check("R6 clear drops line", {31'b0, irq_n}, 32'h1);
    rd_chk("R4 held low no retrigger", 12'h100, 32'h0000_0400);

    // R3 low level on input 11 stays pending across service
    wr(12'h02C, 32'h0000_0003);
    wr(12'h120, 32'h0000_0800);
    check("R3 inactive level", {31'b0, irq_n}, 32'h1);
    @(negedge clk); src_i[11] = 1'b0;
    @(negedge clk);
    check("R3 level asserts", {31'b0, irq_n}, 32'h0);
    rd_chk("R3 pe", 12'h10C, 32'h8000_000B);
    wr(12'h130, 32'h0);
    check("R9 level still pending", {31'b0, irq_n}, 32'h0);
    rd_chk("R3 pe again", 12'h10C, 32'h8000_000B);
    @(negedge clk); src_i[11] = 1'b1;
    @(negedge clk);
    wr(12'h130, 32'h0);
    check("R3 level gone", {31'b0, irq_n}, 32'h1);
    rd_chk("R3 raw", 12'h100, 32'h0000_0400);
    rd_chk("R8 empty pe", 12'h10C, 32'h0);
    check("R8 empty keeps idle", {31'b0, irq_n}, 32'h1);

    // R11 read data holds; R5 zero bits change nothing
    rd_chk("R5 enables", 12'h114, 32'h0210_0AAC);
    wr(12'h124, 32'h0);
    check("R11 rdata held", bus_rdata, 32'h0210_0AAC);
    rd_chk("R5 zero write", 12'h114, 32'h0210_0AAC);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule